// File: doc/BRIEF.md
# Register-to-Register ALU with Negative/Zero/Carry Flags

This block is the arithmetic unit a small 16-bit core uses for its register-to-register instructions. Each cycle it takes a 7-bit opcode and two 16-bit operands and produces three combinational outputs: a 16-bit result, a write enable for the destination register, and the next value of the three condition flags. It also holds the condition flags in a register, which it loads on the clock edge when an arithmetic instruction executes.

The two-source operations, add and subtract, combine source A with source B. The single-source operations use source B alone: move, shift left, logical shift right, increment and decrement. Compare computes A minus B only to set the flags, so it never asserts the write enable.

Every operation finishes in one cycle, so the block has no back-pressure. The `exec_en` strobe marks a cycle that carries an instruction, and the block applies no other handshake at its edges.

Top module: `nzc_alu`

## Requirements
- R1: Opcode 1110000 (add) gives result = A + B modulo 2^16, C = carry out of bit 15, and wr_en = 1 while exec_en is high.
- R2: Opcode 1110001 (subtract) gives result = A - B modulo 2^16, with C = 1 exactly when B > A as unsigned values (borrow), and wr_en = 1 while exec_en is high.
- R3: Opcode 1110010 (compare) produces the same result and flags as subtract, but wr_en is always 0.
- R4: Opcode 1110011 (move) gives result = B and C = 0.
- R5: Opcode 1110100 (shift left) gives result = B shifted left one place with a zero fill, and C = B[15]. Opcode 1110101 (shift right) gives result = B shifted right logically one place, and C = B[0].
- R6: Opcode 1110110 (increment) gives result = B + 1 with C = 1 only when B = 16'hFFFF. Opcode 1110111 (decrement) gives result = B - 1 with C = 1 only when B = 0.
- R7: The flag vector is {N, Z, C} on bits 2..0. For opcodes 1110000..1110111 with exec_en high, flags_next has N = result[15] and Z = 1 exactly when result is 0.
- R8: On a rising clock edge where exec_en is high and the opcode lies in 1110000..1110111, flags_q takes the value of flags_next.
- R9: For any opcode outside 1110000..1110111, result is 0. When exec_en is low or the opcode lies outside that range, wr_en is 0, flags_next equals flags_q, and flags_q keeps its value across the edge.
- R10: While rst_n is low, flags_q is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| exec_en | input | 1 | High in a cycle that executes the opcode on the inputs |
| opcode | input | 7 | Instruction opcode |
| src_a | input | 16 | Source A operand |
| src_b | input | 16 | Source B operand |
| result | output | 16 | Combinational result |
| wr_en | output | 1 | Destination register write enable |
| flags_next | output | 3 | Next flag values {N,Z,C} |
| flags_q | output | 3 | Registered flags {N,Z,C} |

## Verification
The bench targets the points where carry and borrow are easy to get backwards. The cases are FFFF+1, 0-1, equal operands, increment of FFFF and decrement of 0. A design that inverts the borrow sense, or that takes carry rather than borrow for subtract, reports the wrong C in exactly these cases. Further vectors check compare with operands that would write, move issued while C was previously set, and shifts of patterns whose edge bits are 1. These catch a compare that writes the register, a move that keeps the old carry, or a shift that takes C from the wrong end. Non-arithmetic opcodes and cycles with exec_en low are applied while the flags are non-zero, so a register that updates when it should hold changes a visible value.

// File: rtl/nzc_alu_pkg.sv
package nzc_alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_CMP = 3'd2,
    FN_MOV = 3'd3,
    FN_SHL = 3'd4,
    FN_SHR = 3'd5,
    FN_INC = 3'd6,
    FN_DEC = 3'd7
  } alu_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } nzc_t;

  localparam logic [3:0] ALU_GROUP = 4'b1110;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import nzc_alu_pkg::*;
#(
  parameter int OPW = 7
) (
  input  logic [OPW-1:0] opcode,
  input  logic           exec_en,
  output logic           is_alu,
  output logic           do_update,
  output logic           do_write,
  output alu_fn_e        fn
);
  localparam int GW = OPW - 3;

  always_comb begin
    is_alu    = (opcode[OPW-1:3] == GW'(ALU_GROUP));
    fn        = alu_fn_e'(opcode[2:0]);
    do_update = is_alu && exec_en;
    do_write  = do_update && (fn != FN_CMP);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import nzc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_fn_e        fn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum,
  output logic           c_flag
);
  logic [W-1:0] x, y;
  logic         inv, cin;
  logic [W:0]   wide;

  always_comb begin
    x   = a;
    y   = b;
    inv = 1'b0;
    cin = 1'b0;
    case (fn)
      FN_ADD: begin x = a; y = b; inv = 1'b0; cin = 1'b0; end
      FN_SUB,
      FN_CMP: begin x = a; y = b; inv = 1'b1; cin = 1'b1; end
      FN_INC: begin x = b; y = '0; inv = 1'b0; cin = 1'b1; end
      FN_DEC: begin x = b; y = '0; inv = 1'b1; cin = 1'b0; end
      default: begin x = a; y = b; inv = 1'b0; cin = 1'b0; end
    endcase
    wide   = {1'b0, x} + {1'b0, (y ^ {W{inv}})} + {{W{1'b0}}, cin};
    sum    = wide[W-1:0];
    c_flag = wide[W] ^ inv;
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import nzc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         c_flag
);
  always_comb begin
    case (fn)
      FN_SHL:  begin res = {b[W-2:0], 1'b0}; c_flag = b[W-1]; end
      FN_SHR:  begin res = {1'b0, b[W-1:1]}; c_flag = b[0];   end
      default: begin res = b;                c_flag = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import nzc_alu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  nzc_t d,
  output nzc_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/nzc_alu.sv
module nzc_alu
  import nzc_alu_pkg::*;
#(
  parameter int W   = 16,
  parameter int OPW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_en,
  input  logic [OPW-1:0] opcode,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic [2:0]     flags_next,
  output logic [2:0]     flags_q
);
  logic         is_alu, do_update, do_write;
  alu_fn_e      fn;
  logic [W-1:0] arith_res, shift_res, dp_res;
  logic         arith_c, shift_c, dp_c;
  logic         use_shift;
  nzc_t         computed, nxt, held;

  alu_decode #(.OPW(OPW)) u_dec (
    .opcode(opcode), .exec_en(exec_en), .is_alu(is_alu),
    .do_update(do_update), .do_write(do_write), .fn(fn)
  );

  alu_addsub #(.W(W)) u_add (
    .fn(fn), .a(src_a), .b(src_b), .sum(arith_res), .c_flag(arith_c)
  );

  alu_shift #(.W(W)) u_shf (
    .fn(fn), .b(src_b), .res(shift_res), .c_flag(shift_c)
  );

  always_comb begin
    use_shift  = (fn == FN_MOV) || (fn == FN_SHL) || (fn == FN_SHR);
    dp_res     = use_shift ? shift_res : arith_res;
    dp_c       = use_shift ? shift_c   : arith_c;
    computed.n = dp_res[W-1];
    computed.z = (dp_res == '0);
    computed.c = dp_c;
    nxt        = do_update ? computed : held;
  end

  alu_flags u_flg (
    .clk(clk), .rst_n(rst_n), .load(do_update), .d(nxt), .q(held)
  );

  assign result     = is_alu ? dp_res : '0;
  assign wr_en      = do_write;
  assign flags_next = nxt;
  assign flags_q    = held;
endmodule

// File: rtl/nzc_alu_chk.sv
module nzc_alu_chk #(
  parameter int W   = 16,
  parameter int OPW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           exec_en,
  input logic [OPW-1:0] opcode,
  input logic [W-1:0]   src_b,
  input logic [W-1:0]   result,
  input logic           wr_en,
  input logic [2:0]     flags_next,
  input logic [2:0]     flags_q
);
  logic in_grp;
  assign in_grp = (opcode[OPW-1:3] == (OPW-3)'(4'b1110));

  a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_grp && opcode[2:0] == 3'd2) |-> !wr_en);

  a_r4_mov_clears_c: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && in_grp && opcode[2:0] == 3'd3) |-> !flags_next[0]);

  a_r5_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && in_grp && opcode[2:0] == 3'd4) |-> (flags_next[0] == src_b[W-1]));

  a_r5_shr_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && in_grp && opcode[2:0] == 3'd5) |-> (flags_next[0] == src_b[0]));

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && in_grp) |-> (flags_next[1] == (result == '0)));

  a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && in_grp) |-> (flags_next[2] == result[W-1]));

  a_r8_flags_load: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && in_grp) |=> (flags_q == $past(flags_next)));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && in_grp) |=> $stable(flags_q));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && in_grp) |-> (!wr_en && flags_next == flags_q));
endmodule

bind nzc_alu nzc_alu_chk #(.W(W), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
  .src_b(src_b), .result(result), .wr_en(wr_en),
  .flags_next(flags_next), .flags_q(flags_q)
);

// File: tb/nzc_alu_tb.sv
module nzc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [6:0]  opcode = '0;
  logic [15:0] src_a = '0, src_b = '0;
  logic [15:0] result;
  logic        wr_en;
  logic [2:0]  flags_next, flags_q;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [2:0] exp_fq = 3'b000;

  always #5 clk = ~clk;

  nzc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .result(result), .wr_en(wr_en),
    .flags_next(flags_next), .flags_q(flags_q)
  );

  function automatic string req_of(input logic [6:0] op, input logic en);
    if (op[6:3] != 4'b1110 || !en) return "R9";
    case (op[2:0])
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic en);
    int ai, bi, s;
    bit c, grp, upd;
    logic [15:0] e_res;
    logic e_we;
    logic [2:0] e_fn;
    string rq;
    @(negedge clk);
    opcode = op; src_a = a; src_b = b; exec_en = en;
    #1;
    ai = int'(a); bi = int'(b);
    grp = (op[6:3] == 4'b1110);
    upd = grp && en;
    s = 0; c = 0;
    case (op[2:0])
      3'd0: begin s = ai + bi; c = (s > 65535); end
      3'd1, 3'd2: begin s = ai - bi; c = (ai < bi); end
      3'd3: begin s = bi; c = 0; end
      3'd4: begin s = bi * 2; c = (bi >= 32768); end
      3'd5: begin s = bi / 2; c = (bi % 2 == 1); end
      3'd6: begin s = bi + 1; c = (bi == 65535); end
      default: begin s = bi - 1; c = (bi == 0); end
    endcase
    e_res = grp ? s[15:0] : 16'h0000;
    e_we  = upd && (op[2:0] != 3'd2);
    e_fn  = upd ? {e_res[15], e_res == 16'h0000, c} : exp_fq;
    rq = req_of(op, en);
    check(rq, "result", int'(e_res) == int'(result) ? int'(e_res) : int'(result), int'(e_res));
    check(rq, "wr_en", int'(wr_en), int'(e_we));
    check(upd ? "R7" : "R9", "flags_next", int'(flags_next), int'(e_fn));
    check("R8", "flags_q", int'(flags_q), int'(exp_fq));
    @(posedge clk);
    if (upd) exp_fq = e_fn;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "flags_q in reset", int'(flags_q), 0);
    rst_n = 1'b1;

    apply(7'b1110000, 16'hFFFF, 16'h0001, 1);  // R1 carry, zero
    apply(7'b1110000, 16'h1234, 16'h4321, 1);  // R1 plain
    apply(7'b1110001, 16'h0000, 16'h0001, 1);  // R2 borrow, negative
    apply(7'b1110001, 16'h0005, 16'h0003, 1);  // R2 no borrow
    apply(7'b1110010, 16'h0042, 16'h0042, 1);  // R3 equal, no write
    apply(7'b1110010, 16'h0001, 16'h8000, 1);  // R3 borrow
    apply(7'b1110011, 16'h0000, 16'h0000, 1);  // R4 C cleared from set
    apply(7'b1110100, 16'h0000, 16'h8001, 1);  // R5 shl edge bit
    apply(7'b1110101, 16'h0000, 16'h8001, 1);  // R5 shr logical
    apply(7'b1110110, 16'h0000, 16'hFFFF, 1);  // R6 inc wrap
    apply(7'b1110111, 16'h0000, 16'h0000, 1);  // R6 dec borrow
    apply(7'b1111000, 16'h0000, 16'h0000, 1);  // R9 other opcode holds
    apply(7'b1110000, 16'h0000, 16'h0000, 0);  // R9 exec_en low holds
    apply(7'b0000000, 16'hFFFF, 16'hFFFF, 1);  // R9 other group

    for (int i = 0; i < 3000; i++) begin
      logic [6:0] op;
      op = $urandom_range(0, 3) != 0 ? {4'b1110, 3'($urandom)} : 7'($urandom);
      apply(op, 16'($urandom), 16'($urandom), $urandom_range(0, 7) != 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule